// File: doc/BRIEF.md
# Control Panel Status Frame Transmitter

This block sits in a front control panel and reports the panel's state to a main unit over one asynchronous serial line. On a fixed period it captures every analog reading and button input in a single clock edge. It also takes the step counts that two rotary encoders have built up since the previous frame. It then sends a 13-octet frame through an internal 8N1 transmitter, least significant bit first.

The frame synchronises itself. Only the leading octet has its top bit set, so a receiver can find the frame boundary from any point in the stream. The first two octets hold the left and right encoder counts as 7-bit two's-complement values, with clockwise positive. Each count saturates and never wraps. Octets 2 to 8 carry seven 7-bit readings. Octets 9 and 10 carry the right-side and left-side button groups. Octets 11 and 12 each carry one key in bit 0.

By default the bit time and the frame period are 5208 and 2,000,000 clock cycles, which gives 19.2 kbps and 20 ms at 100 MHz. Both are parameters. The frame period must be longer than 130 bit times.

Top module: `panel_frame_tx`

## Requirements
- R1: While reset is held, `txLine` is 1 and `frameDone` is 0.
- R2: The first frame is captured on the first clock edge after reset is released (edge E). Later frames are captured every FRAME_CYCLES cycles after E. `txLine` is still 1 just after a capture edge.
- R3: Each octet is sent as 10 slots of BIT_CYCLES cycles each: a 0 start bit, data bits 0 to 7, then a 1 stop bit. The 13 octets follow one another with no gap. Slot s of octet n starts on the edge E + k·FRAME_CYCLES + 1 + (10n+s)·BIT_CYCLES.
- R4: Bit 7 is 1 in octet 0 and 0 in octets 1 to 12.
- R5: Octets 2 to 10 carry, in bits 6:0: push-to-talk level, right squelch, right volume, keypad row level, left squelch, left volume, keypad column level, right buttons, left buttons.
- R6: Octets 0 and 1 hold the left and right encoder counts (7-bit two's complement). A step pulse with `encCw*`=1 adds 1, and a step with `encCw*`=0 subtracts 1.
- R7: An encoder count stops at +63 (3Fh) and at -64 (40h). Further steps in the same direction leave it unchanged.
- R8: A count is cleared on the capture edge that latches it. A step sampled on that same edge counts toward the next frame.
- R9: Input changes after a capture edge have no effect on the frame being sent.
- R10: Octet 11 carries `setKey` in bit 0 and octet 12 carries `memKey` in bit 0. All other bits of both octets are 0.
- R11: `frameDone` is high for exactly one cycle, following the edge E + k·FRAME_CYCLES + 130·BIT_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| encStepL | input | 1 | Left encoder step pulse, one count per cycle high |
| encCwL | input | 1 | Left encoder direction, 1 = clockwise |
| encStepR | input | 1 | Right encoder step pulse |
| encCwR | input | 1 | Right encoder direction, 1 = clockwise |
| pttLevel | input | 7 | Push-to-talk analog reading |
| sqlRight | input | 7 | Right squelch reading (7Fh fully open) |
| volRight | input | 7 | Right volume reading (7Fh maximum) |
| rowLevel | input | 7 | Keypad row analog reading |
| sqlLeft | input | 7 | Left squelch reading |
| volLeft | input | 7 | Left volume reading |
| colLevel | input | 7 | Keypad column analog reading |
| btnRight | input | 7 | Right-side button bits |
| btnLeft | input | 7 | Left-side button bits |
| setKey | input | 1 | SET key state |
| memKey | input | 1 | Memory key state |
| txLine | output | 1 | Serial output, idle high |
| frameDone | output | 1 | One-cycle strobe when a frame is complete |

## Verification
Every result here falls on a fixed cycle counted from the capture edge. The line is still idle just after that edge. Slot s of octet n appears one register later than the sequencer state, at 1 + (10n+s)·BIT_CYCLES, and `frameDone` follows edge 130·BIT_CYCLES. The bench keeps its own count of clock edges and works out each of these positions from the requirements. It samples every bit at mid-slot on the falling edge, and checks `frameDone` on its exact cycle and the cycle after. Encoder steps and input changes are driven on falling edges, placed against known capture edges, so the bench knows which frame each one belongs to.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int PAYLOAD_W = 7;
  localparam int ENC_COUNT = 2;
  localparam int OCTETS    = 13;
  localparam int SAMPLED   = OCTETS - ENC_COUNT;
  localparam int SLOTS     = 10;
  localparam int OCT_W     = $clog2(OCTETS);
  localparam int SLOT_W    = $clog2(SLOTS);

  typedef struct packed {
    logic              snap;
    logic              busy;
    logic [OCT_W-1:0]  octetIdx;
    logic [SLOT_W-1:0] slotIdx;
  } txCtrl_t;
endpackage

// File: rtl/pft_step_acc.sv
module pft_step_acc #(
  parameter int W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                step,
  input  logic                cw,
  output logic signed [W-1:0] count
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] base;
  logic signed [W-1:0] nextCount;

  always_comb begin
    base      = clear ? '0 : count;
    nextCount = base;
    if (step) begin
      if (cw && base != MAXV)       nextCount = base + 1'b1;
      else if (!cw && base != MINV) nextCount = base - 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) count <= '0;
    else     count <= nextCount;
  end

  a_r6_cw_step: assert property (@(posedge clk) disable iff (rst)
    (!clear && step && cw && count != MAXV) |=> count == $past(count) + 1'b1);
  a_r7_sat_high: assert property (@(posedge clk) disable iff (rst)
    (!clear && step && cw && count == MAXV) |=> count == MAXV);
  a_r7_sat_low: assert property (@(posedge clk) disable iff (rst)
    (!clear && step && !cw && count == MINV) |=> count == MINV);
  a_r8_clear_idle: assert property (@(posedge clk) disable iff (rst)
    (clear && !step) |=> count == '0);
endmodule

// File: rtl/pft_control.sv
module pft_control
  import pft_pkg::*;
#(
  parameter int BIT_CYCLES   = 5208,
  parameter int FRAME_CYCLES = 2000000
) (
  input  logic    clk,
  input  logic    rst,
  output txCtrl_t ctrl,
  output logic    frameDone
);
  localparam int FC_W = $clog2(FRAME_CYCLES);
  localparam int BT_W = $clog2(BIT_CYCLES);

  logic [FC_W-1:0]   frameCnt;
  logic [BT_W-1:0]   bitTmr;
  logic [OCT_W-1:0]  octetIdx;
  logic [SLOT_W-1:0] slotIdx;
  logic              busy;
  logic              startNow;
  logic              bitEnd;
  logic              lastSlot;
  logic              lastOctet;

  assign startNow  = (frameCnt == '0);
  assign bitEnd    = busy && (bitTmr == BT_W'(BIT_CYCLES - 1));
  assign lastSlot  = (slotIdx == SLOT_W'(SLOTS - 1));
  assign lastOctet = (octetIdx == OCT_W'(OCTETS - 1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      frameCnt  <= '0;
      bitTmr    <= '0;
      octetIdx  <= '0;
      slotIdx   <= '0;
      busy      <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameCnt  <= (frameCnt == FC_W'(FRAME_CYCLES - 1)) ? '0 : frameCnt + 1'b1;
      frameDone <= 1'b0;
      if (startNow) begin
        busy     <= 1'b1;
        octetIdx <= '0;
        slotIdx  <= '0;
        bitTmr   <= '0;
      end else if (busy) begin
        if (bitEnd) begin
          bitTmr <= '0;
          if (lastSlot) begin
            slotIdx <= '0;
            if (lastOctet) begin
              busy      <= 1'b0;
              frameDone <= 1'b1;
            end else begin
              octetIdx <= octetIdx + 1'b1;
            end
          end else begin
            slotIdx <= slotIdx + 1'b1;
          end
        end else begin
          bitTmr <= bitTmr + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl.snap     = startNow;
    ctrl.busy     = busy;
    ctrl.octetIdx = octetIdx;
    ctrl.slotIdx  = slotIdx;
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone);
  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> ($past(busy) && !busy));
  a_r3_octet_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (octetIdx < OCT_W'(OCTETS) && slotIdx < SLOT_W'(SLOTS)));
endmodule

// File: rtl/pft_datapath.sv
module pft_datapath
  import pft_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  txCtrl_t              ctrl,
  input  logic [ENC_COUNT-1:0] encStep,
  input  logic [ENC_COUNT-1:0] encCw,
  input  logic [PAYLOAD_W-1:0] fieldIn [SAMPLED],
  output logic                 txLine
);
  logic signed [PAYLOAD_W-1:0] encCount [ENC_COUNT];
  logic [PAYLOAD_W-1:0]        frameWord [OCTETS];
  logic [PAYLOAD_W-1:0]        snapReg [OCTETS];
  logic [PAYLOAD_W:0]          curOctet;
  logic [SLOT_W-1:0]           dataSel;
  logic                        txBit;

  for (genvar g = 0; g < ENC_COUNT; g++) begin : g_enc
    pft_step_acc #(.W(PAYLOAD_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .clear (ctrl.snap),
      .step  (encStep[g]),
      .cw    (encCw[g]),
      .count (encCount[g])
    );
  end

  for (genvar g = 0; g < OCTETS; g++) begin : g_word
    if (g < ENC_COUNT) begin : g_from_enc
      assign frameWord[g] = encCount[g];
    end else begin : g_from_in
      assign frameWord[g] = fieldIn[g - ENC_COUNT];
    end
    always_ff @(posedge clk or posedge rst) begin
      if (rst)            snapReg[g] <= '0;
      else if (ctrl.snap) snapReg[g] <= frameWord[g];
    end
  end

  always_comb begin
    if (ctrl.octetIdx < OCT_W'(OCTETS))
      curOctet = {ctrl.octetIdx == '0, snapReg[ctrl.octetIdx]};
    else
      curOctet = '1;
    dataSel = ctrl.slotIdx - 1'b1;
    if (ctrl.slotIdx == '0)                       txBit = 1'b0;
    else if (ctrl.slotIdx == SLOT_W'(SLOTS - 1))  txBit = 1'b1;
    else                                          txBit = curOctet[dataSel[2:0]];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) txLine <= 1'b1;
    else     txLine <= ctrl.busy ? txBit : 1'b1;
  end

  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl.busy) |-> txLine);
  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    (ctrl.busy && ctrl.slotIdx == '0) |=> !txLine);
  a_r4_lead_marker: assert property (@(posedge clk) disable iff (rst)
    (ctrl.busy && ctrl.slotIdx == SLOT_W'(8) && ctrl.octetIdx == '0) |=> txLine);
  a_r4_other_marker: assert property (@(posedge clk) disable iff (rst)
    (ctrl.busy && ctrl.slotIdx == SLOT_W'(8) && ctrl.octetIdx != '0) |=> !txLine);
endmodule

// File: rtl/panel_frame_tx.sv
module panel_frame_tx
  import pft_pkg::*;
#(
  parameter int BIT_CYCLES   = 5208,
  parameter int FRAME_CYCLES = 2000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       encStepL,
  input  logic       encCwL,
  input  logic       encStepR,
  input  logic       encCwR,
  input  logic [6:0] pttLevel,
  input  logic [6:0] sqlRight,
  input  logic [6:0] volRight,
  input  logic [6:0] rowLevel,
  input  logic [6:0] sqlLeft,
  input  logic [6:0] volLeft,
  input  logic [6:0] colLevel,
  input  logic [6:0] btnRight,
  input  logic [6:0] btnLeft,
  input  logic       setKey,
  input  logic       memKey,
  output logic       txLine,
  output logic       frameDone
);
  txCtrl_t              ctrl;
  logic [PAYLOAD_W-1:0] fields [SAMPLED];

  assign fields[0]  = pttLevel;
  assign fields[1]  = sqlRight;
  assign fields[2]  = volRight;
  assign fields[3]  = rowLevel;
  assign fields[4]  = sqlLeft;
  assign fields[5]  = volLeft;
  assign fields[6]  = colLevel;
  assign fields[7]  = btnRight;
  assign fields[8]  = btnLeft;
  assign fields[9]  = {{(PAYLOAD_W-1){1'b0}}, setKey};
  assign fields[10] = {{(PAYLOAD_W-1){1'b0}}, memKey};

  pft_control #(
    .BIT_CYCLES   (BIT_CYCLES),
    .FRAME_CYCLES (FRAME_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .frameDone (frameDone)
  );

  pft_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .encStep ({encStepR, encStepL}),
    .encCw   ({encCwR, encCwL}),
    .fieldIn (fields),
    .txLine  (txLine)
  );
endmodule

// File: tb/panel_frame_tx_tb.sv
module panel_frame_tx_tb;
  localparam int BIT_C   = 4;
  localparam int FRAME_C = 800;
  localparam int NOCT    = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       encStepL = 0, encCwL = 0, encStepR = 0, encCwR = 0;
  logic [6:0] pttLevel, sqlRight, volRight, rowLevel, sqlLeft, volLeft, colLevel;
  logic [6:0] btnRight, btnLeft;
  logic       setKey, memKey;
  logic       txLine, frameDone;

  panel_frame_tx #(.BIT_CYCLES(BIT_C), .FRAME_CYCLES(FRAME_C)) u_dut (
    .clk(clk), .rst(rst),
    .encStepL(encStepL), .encCwL(encCwL), .encStepR(encStepR), .encCwR(encCwR),
    .pttLevel(pttLevel), .sqlRight(sqlRight), .volRight(volRight), .rowLevel(rowLevel),
    .sqlLeft(sqlLeft), .volLeft(volLeft), .colLevel(colLevel),
    .btnRight(btnRight), .btnLeft(btnLeft), .setKey(setKey), .memKey(memKey),
    .txLine(txLine), .frameDone(frameDone)
  );

  int edgeCount = 0;
  always @(posedge clk) edgeCount <= edgeCount + 1;

  int errors = 0;
  int checks = 0;
  int e0 = 0;
  logic [7:0] got [NOCT];
  logic [7:0] exp [NOCT];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic toNeg(int target);
    while (edgeCount < target) @(negedge clk);
  endtask

  function automatic int frameStart(int k);
    return e0 + k * FRAME_C;
  endfunction

  // Expected frame from the current input values (R4, R5, R10 field layout)
  task automatic buildExp(logic [6:0] eL, logic [6:0] eR);
    exp[0]  = {1'b1, eL};
    exp[1]  = {1'b0, eR};
    exp[2]  = {1'b0, pttLevel};
    exp[3]  = {1'b0, sqlRight};
    exp[4]  = {1'b0, volRight};
    exp[5]  = {1'b0, rowLevel};
    exp[6]  = {1'b0, sqlLeft};
    exp[7]  = {1'b0, volLeft};
    exp[8]  = {1'b0, colLevel};
    exp[9]  = {1'b0, btnRight};
    exp[10] = {1'b0, btnLeft};
    exp[11] = {7'b0, setKey};
    exp[12] = {7'b0, memKey};
  endtask

  // Receives frame k at the slot positions given by R3, checks R2, R3, R11
  task automatic recvFrame(int k);
    int fs = frameStart(k);
    toNeg(fs);
    check("R2", "line idle at capture edge", 32'(txLine), 1);
    toNeg(fs + 1);
    check("R2", "start bit begins one edge after capture", 32'(txLine), 0);
    for (int n = 0; n < NOCT; n++) begin
      for (int s = 0; s < 10; s++) begin
        toNeg(fs + 1 + (n * 10 + s) * BIT_C + BIT_C / 2);
        if (s == 0)      check("R3", $sformatf("start bit octet %0d", n), 32'(txLine), 0);
        else if (s == 9) check("R3", $sformatf("stop bit octet %0d", n), 32'(txLine), 1);
        else             got[n][s-1] = txLine;
      end
    end
    check("R11", "frameDone low before end", 32'(frameDone), 0);
    toNeg(fs + 130 * BIT_C);
    check("R11", "frameDone high", 32'(frameDone), 1);
    toNeg(fs + 130 * BIT_C + 1);
    check("R11", "frameDone one cycle", 32'(frameDone), 0);
    check("R3", "idle after frame", 32'(txLine), 1);
  endtask

  task automatic compareFrame(int k);
    for (int n = 0; n < NOCT; n++) begin
      string req = (n < 2) ? "R6" : (n < 11) ? "R5" : "R10";
      check("R4", $sformatf("frame %0d octet %0d top bit", k, n), 32'(got[n][7]), 32'(n == 0));
      check(req, $sformatf("frame %0d octet %0d", k, n), 32'(got[n]), 32'(exp[n]));
    end
  endtask

  task automatic stepBoth(int nL, logic cwL, int nR, logic cwR);
    int m = (nL > nR) ? nL : nR;
    encCwL = cwL;
    encCwR = cwR;
    for (int i = 0; i < m; i++) begin
      encStepL = (i < nL);
      encStepR = (i < nR);
      @(negedge clk);
    end
    encStepL = 0;
    encStepR = 0;
  endtask

  task automatic testReset();
    toNeg(3);
    check("R1", "txLine in reset", 32'(txLine), 1);
    check("R1", "frameDone in reset", 32'(frameDone), 0);
    toNeg(5);
    rst = 1'b0;
    e0 = edgeCount + 1;
  endtask

  // Frame 0: baseline layout; inputs change mid-frame (R9)
  task automatic testLayoutAndSnapshot();
    buildExp(7'h00, 7'h00);
    fork
      recvFrame(0);
      begin
        toNeg(frameStart(0) + 20);
        pttLevel = 7'h01; sqlRight = 7'h7F; volRight = 7'h02; rowLevel = 7'h03;
        sqlLeft = 7'h04; volLeft = 7'h7F; colLevel = 7'h05;
        btnRight = 7'h55; btnLeft = 7'h0F; setKey = 1'b0; memKey = 1'b1;
      end
    join
    compareFrame(0);  // R9: frame 0 holds the values captured before the change
  endtask

  // Frame 1: counts of +5 and -3, new inputs visible (R6)
  task automatic testCounts();
    stepBoth(5, 1'b1, 3, 1'b0);
    buildExp(7'h05, 7'h7D);
    recvFrame(1);
    compareFrame(1);
  endtask

  // Frame 2: 70 steps each way saturate at 3Fh and 40h (R7)
  task automatic testSaturation();
    stepBoth(70, 1'b1, 70, 1'b0);
    buildExp(7'h3F, 7'h40);
    recvFrame(2);
    compareFrame(2);
  endtask

  // Frames 3 and 4: steps on the capture edge carry to the next frame (R8)
  task automatic testCaptureEdgeStep();
    stepBoth(2, 1'b1, 0, 1'b1);
    toNeg(frameStart(3) - 1);
    encCwL = 1'b1; encStepL = 1'b1;
    encCwR = 1'b0; encStepR = 1'b1;
    toNeg(frameStart(3));
    encStepL = 1'b0; encStepR = 1'b0;
    buildExp(7'h02, 7'h00);
    recvFrame(3);
    compareFrame(3);
    buildExp(7'h01, 7'h7F);
    recvFrame(4);
    compareFrame(4);
  endtask

  initial begin
    pttLevel = 7'h11; sqlRight = 7'h22; volRight = 7'h33; rowLevel = 7'h44;
    sqlLeft = 7'h55; volLeft = 7'h66; colLevel = 7'h7F;
    btnRight = 7'h2A; btnLeft = 7'h15; setKey = 1'b1; memKey = 1'b0;
    testReset();
    testLayoutAndSnapshot();
    testCounts();
    testSaturation();
    testCaptureEdgeStep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule